// File: doc/BRIEF.md
# External Trigger Timestamp Capture

This block stamps external events with the current time of a free-running time base. Each of a parameterised number of trigger inputs (two by default) is synchronised, edge-detected on a software-chosen polarity and, on every qualifying edge, the 64-bit time seen on the detection cycle is pushed into that input's own FIFO. A per-input loopback select lets a pulse-generator output replace the external pin, so the output chain can be measured without external wiring.

Software drains a FIFO by reading the head entry as two 32-bit halves. The low half is read first and does not disturb the FIFO. Reading the high half returns the upper word and pops the entry. A per-input valid flag stays high while the FIFO holds data. Three sticky event flags per input (new stamp, fill threshold reached, overflow) sit at fixed bit positions in a 32-bit event word. They are cleared by a write-one-to-clear strobe and combined with a mask into one interrupt line.

Top module: `trig_stamp_capture`

## Requirements
- R1: With polarity bit 0 for input i, a low-to-high transition captures the `cur_time` value present in the cycle after the input has passed two synchroniser flops. For a pin change just after clock edge k, that is the value held between edges k+2 and k+3.
- R2: With polarity bit 1 for input i, only high-to-low transitions are captured. Transitions of the opposite direction store nothing.
- R3: `ts_valid[i]` is 1 exactly while input i's FIFO holds at least one stamp. Stamps leave in capture order.
- R4: `rd_data` shows the head entry of the input selected by `rd_sel`. It shows bits 31:0 when `rd_hi`=0 and bits 63:32 when `rd_hi`=1. A cycle with `rd_en`=1 and `rd_hi`=1 pops the entry, while low-half reads leave it in place.
- R5: Every stored stamp for input i sets event bit 24+i.
- R6: Event bit 20+i is set when a capture raises input i's fill count to the threshold value. The threshold resets to 7 and is loaded from `thr_wdata` when `thr_we` is 1.
- R7: Each FIFO holds DEPTH (16) stamps. A capture arriving at a full FIFO with no pop in the same cycle is dropped and sets event bit 28+i. The stored stamps are unchanged.
- R8: When `loop_en[i]`=1, `loop_src[i]` drives input i's edge detector and `trig_pin[i]` is ignored.
- R9: Event flags are sticky until a cycle with `ev_clr`=1 clears the flags whose `ev_clr_bits` are 1. `irq` is 1 when any flag is 1 and its `ev_mask` bit is 1. The mask never alters the flags.
- R10: After reset, all valid bits, event flags, `irq` and `rd_data` are 0.
- R11: A high-half read of an empty FIFO returns 0 and changes nothing. Later captures read back correctly.
- R12: Inputs are independent. A capture on one input changes no other input's valid bit or FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | 64 | Current time from the time base |
| trig_pin | input | NUM_IN | External trigger pins |
| loop_src | input | NUM_IN | Pulse-channel outputs for loopback |
| loop_en | input | NUM_IN | Per-input loopback select |
| edge_fall | input | NUM_IN | Per-input polarity, 1 selects the falling edge |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | CNT_W | New fill threshold |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | SEL_W | Input selected for reading |
| rd_hi | input | 1 | 1 selects the upper half, and pops when rd_en is 1 |
| rd_data | output | 32 | Selected half of the head entry |
| ts_valid | output | NUM_IN | FIFO non-empty per input |
| ev_clr | input | 1 | Event clear strobe |
| ev_clr_bits | input | 32 | Flags to clear when ev_clr is 1 |
| ev_mask | input | 32 | Interrupt mask |
| ev_flags | output | 32 | Sticky event flags |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench targets the capture instant: a synchroniser that is one flop short or long stores a time one count off, which the scoreboard catches because the time base advances every cycle and crosses a 32-bit boundary. It fills a FIFO to exactly the threshold and then one stamp past full. An off-by-one on the count would fire the threshold a stamp early, or would accept, overwrite or lose a stamp, and the drain exposes each of these. It reads the low half twice before popping, pops an empty FIFO, and toggles the non-selected edge and the non-selected source. A design that popped on the low read, let pointers move on an empty pop, or took the wrong source or edge would return stale or extra stamps.

// File: rtl/tsc_pkg.sv
// Shared constants and types for the trigger timestamp capture block.
package tsc_pkg;
    localparam int WORD_W      = 32;
    localparam int EV_W        = 32;
    // Event word layout, decoded by the interrupt handler; one bit per input.
    localparam int EV_THR_BASE = 20;
    localparam int EV_CAP_BASE = 24;
    localparam int EV_OVF_BASE = 28;
    typedef logic [2*WORD_W-1:0] stamp_t;
endpackage

// File: rtl/tsc_edge_sync.sv
// Two-flop synchroniser followed by a one-edge detector.
// Assumes pin is asynchronous to clk; det is a one-cycle pulse in the
// cycle after the second synchroniser flop takes the new level.
module tsc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic det
);
    logic [2:0] sh;   // [0],[1] synchroniser, [2] previous synchronised level

    // Shift the pin through the synchroniser and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], pin};
    end

    // Flag the selected transition of the synchronised level.
    always_comb det = fall_sel ? (sh[2] & ~sh[1]) : (sh[1] & ~sh[2]);

    // A level can change only once per cycle, so detections never abut.
    AST_DET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> !det);  // R2
endmodule

// File: rtl/tsc_stamp_fifo.sv
// Circular timestamp FIFO with fill count, threshold and overflow pulses.
// Assumes push and pop are single-cycle strobes; a pop on empty is ignored;
// a push when full is dropped unless a pop frees a slot in the same cycle.
module tsc_stamp_fifo
    import tsc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  stamp_t           push_data,
    input  logic             pop,
    input  logic [CNT_W-1:0] thr,
    output stamp_t           head,
    output logic [CNT_W-1:0] count,
    output logic             accepted,
    output logic             thr_hit,
    output logic             ovf_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    stamp_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, empty, pop_ok;

    // Derive occupancy and the accepted operations.
    always_comb begin
        full     = (count == FULL_CNT);
        empty    = (count == '0);
        pop_ok   = pop && !empty;
        accepted = push && (!full || pop_ok);
        ovf_hit  = push && full && !pop_ok;
        thr_hit  = accepted && !pop_ok && ((count + CNT_W'(1)) == thr);
        head     = mem[rd_ptr];
    end

    // Write accepted stamps into the storage array.
    always_ff @(posedge clk) begin
        if (accepted) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accepted) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)   rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            if (accepted && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !accepted) count <= count - 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);  // R7
    AST_OVF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> $stable(count));  // R7
    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count != '0 && !push) |=> count == $past(count) - 1'b1);  // R4
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && !push) |=> count == '0);  // R11
endmodule

// File: rtl/trig_stamp_capture.sv
// Multi-input trigger timestamp capture: per-input source select, edge
// detection, FIFO, split-word read port and a shared sticky event word.
// Assumes NUM_IN <= 4 so the event fields do not overlap, and that cur_time
// is synchronous to clk.
module trig_stamp_capture
    import tsc_pkg::*;
#(
    parameter int NUM_IN    = 2,
    parameter int DEPTH     = 16,
    parameter int THR_RESET = 7,
    parameter int CNT_W     = $clog2(DEPTH + 1),
    parameter int SEL_W     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*WORD_W-1:0] cur_time,
    input  logic [NUM_IN-1:0]   trig_pin,
    input  logic [NUM_IN-1:0]   loop_src,
    input  logic [NUM_IN-1:0]   loop_en,
    input  logic [NUM_IN-1:0]   edge_fall,
    input  logic                thr_we,
    input  logic [CNT_W-1:0]    thr_wdata,
    input  logic                rd_en,
    input  logic [SEL_W-1:0]    rd_sel,
    input  logic                rd_hi,
    output logic [WORD_W-1:0]   rd_data,
    output logic [NUM_IN-1:0]   ts_valid,
    input  logic                ev_clr,
    input  logic [EV_W-1:0]     ev_clr_bits,
    input  logic [EV_W-1:0]     ev_mask,
    output logic [EV_W-1:0]     ev_flags,
    output logic                irq
);
    logic [CNT_W-1:0]  thr_q;
    logic [NUM_IN-1:0] det, acc, thr_hit, ovf_hit, pop;
    stamp_t            head [NUM_IN];
    logic [EV_W-1:0]   ev_set;

    // Hold the fill threshold shared by all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_q <= CNT_W'(THR_RESET);
        else if (thr_we) thr_q <= thr_wdata;
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        logic             src;
        logic [CNT_W-1:0] cnt;

        // Choose between the external pin and the looped-back pulse.
        always_comb src = loop_en[i] ? loop_src[i] : trig_pin[i];
        // Pop only on a high-half read of this input.
        always_comb pop[i] = rd_en && rd_hi && (rd_sel == SEL_W'(i));

        tsc_edge_sync u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (src),
            .fall_sel (edge_fall[i]),
            .det      (det[i])
        );

        tsc_stamp_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (det[i]),
            .push_data (cur_time),
            .pop       (pop[i]),
            .thr       (thr_q),
            .head      (head[i]),
            .count     (cnt),
            .accepted  (acc[i]),
            .thr_hit   (thr_hit[i]),
            .ovf_hit   (ovf_hit[i])
        );

        // Report a non-empty FIFO.
        always_comb ts_valid[i] = (cnt != '0);

        AST_CAP_EVT: assert property (@(posedge clk) disable iff (!rst_n)
            acc[i] |=> ev_flags[EV_CAP_BASE+i]);  // R5
        AST_OVF_EVT: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_hit[i] |=> ev_flags[EV_OVF_BASE+i]);  // R7
        AST_VALID_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            acc[i] |=> ts_valid[i]);  // R3
    end

    // Present the selected half of the selected head entry, zero if empty.
    always_comb begin
        rd_data = '0;
        if (32'(rd_sel) < NUM_IN && ts_valid[rd_sel])
            rd_data = rd_hi ? head[rd_sel][2*WORD_W-1:WORD_W] : head[rd_sel][WORD_W-1:0];
    end

    // Gather this cycle's event pulses into the event word layout.
    always_comb begin
        ev_set = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            ev_set[EV_THR_BASE+i] = thr_hit[i];
            ev_set[EV_CAP_BASE+i] = acc[i];
            ev_set[EV_OVF_BASE+i] = ovf_hit[i];
        end
    end

    // Keep sticky flags; new events win over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_flags <= '0;
        else        ev_flags <= (ev_flags & ~(ev_clr ? ev_clr_bits : '0)) | ev_set;
    end

    // Combine flags and mask into the interrupt line.
    always_comb irq = |(ev_flags & ev_mask);

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_clr |=> ((ev_flags & $past(ev_flags)) == $past(ev_flags)));  // R9
    AST_RD_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid == '0) |-> (rd_data == '0));  // R11
endmodule

// File: tb/tb_trig_stamp_capture.sv
module tb_trig_stamp_capture;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] T_BASE = 64'h0000_0001_FFFF_FFF0;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] cur_time;
    logic [1:0]  trig_pin = '0, loop_src = '0, loop_en = '0, edge_fall = '0;
    logic        thr_we = 0;
    logic [4:0]  thr_wdata = '0;
    logic        rd_en = 0, rd_hi = 0;
    logic [0:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [1:0]  ts_valid;
    logic        ev_clr = 0;
    logic [31:0] ev_clr_bits = '0, ev_mask = '0, ev_flags;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [63:0] q0 [$];
    logic [63:0] q1 [$];

    trig_stamp_capture dut (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .trig_pin(trig_pin),
        .loop_src(loop_src), .loop_en(loop_en), .edge_fall(edge_fall),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_hi(rd_hi), .rd_data(rd_data), .ts_valid(ts_valid), .ev_clr(ev_clr),
        .ev_clr_bits(ev_clr_bits), .ev_mask(ev_mask), .ev_flags(ev_flags), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running time base stand-in.
    always @(posedge clk) begin
        if (!rst_n) cur_time <= T_BASE;
        else        cur_time <= cur_time + 64'd1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: change one source level and, when a capture is due, record
    // the time the design must store (value between edges k+2 and k+3).
    task automatic drive_src(input int i, input logic v, input bit use_loop, input bit cap);
        @(negedge clk);
        if (use_loop) loop_src[i] = v; else trig_pin[i] = v;
        @(posedge clk); @(posedge clk); @(negedge clk);
        if (cap) begin
            if (i == 0) q0.push_back(cur_time); else q1.push_back(cur_time);
        end
        @(posedge clk);
    endtask

    task automatic read_word(input int i, input bit hi, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1; rd_sel = i[0]; rd_hi = hi;
        #1 d = rd_data;
        @(posedge clk);
        #1 rd_en = 0; rd_hi = 0;
    endtask

    // Monitor: pop the expected stamp and compare with the read-back entry.
    task automatic mon_pop(input int i, input string req);
        logic [31:0] lo, lo2, hi;
        logic [63:0] exp;
        if ((i == 0 ? q0.size() : q1.size()) == 0) begin
            chk(0, {req, " scoreboard empty"}, 0, 0);
            return;
        end
        exp = (i == 0) ? q0.pop_front() : q1.pop_front();
        read_word(i, 0, lo);
        read_word(i, 0, lo2);
        chk(lo == lo2, "R4 low read repeat", {32'd0, lo2}, {32'd0, lo});
        read_word(i, 1, hi);
        chk({hi, lo} == exp, req, {hi, lo}, exp);
    endtask

    task automatic clear_events();
        @(negedge clk); ev_clr = 1; ev_clr_bits = '1;
        @(posedge clk); #1 ev_clr = 0; ev_clr_bits = '0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R10 reset state
        @(negedge clk);
        chk(ts_valid == 0, "R10 valid", 64'(ts_valid), 0);
        chk(ev_flags == 0, "R10 flags", 64'(ev_flags), 0);
        chk(rd_data == 0 && irq == 0, "R10 rd_data/irq", 64'(rd_data), 0);

        // R1 rising capture on input 0
        drive_src(0, 1, 0, 1);
        drive_src(0, 0, 0, 0);
        @(negedge clk);
        chk(ts_valid == 2'b01, "R3 valid after capture", 64'(ts_valid), 1);
        chk(ev_flags[24] && !ev_flags[25], "R5 capture event", 64'(ev_flags), 64'h0100_0000);
        mon_pop(0, "R1 rising stamp");
        @(negedge clk);
        chk(ts_valid == 0, "R3 valid after drain", 64'(ts_valid), 0);

        // R2 falling select on input 1, R12 independence
        @(negedge clk) edge_fall[1] = 1;
        drive_src(1, 1, 0, 0);
        @(negedge clk);
        chk(ts_valid == 0, "R2 rising ignored", 64'(ts_valid), 0);
        drive_src(1, 0, 0, 1);
        @(negedge clk);
        chk(ts_valid == 2'b10, "R12 only input 1 valid", 64'(ts_valid), 2);
        mon_pop(1, "R2 falling stamp");
        @(negedge clk) edge_fall[1] = 0;

        // R9 clear, R6 threshold at default 7
        clear_events();
        @(negedge clk);
        chk(ev_flags == 0, "R9 clear", 64'(ev_flags), 0);
        for (int k = 0; k < 6; k++) begin
            drive_src(0, 1, 0, 1);
            drive_src(0, 0, 0, 0);
        end
        @(negedge clk);
        chk(!ev_flags[20], "R6 not before threshold", 64'(ev_flags), 0);
        drive_src(0, 1, 0, 1);
        drive_src(0, 0, 0, 0);
        @(negedge clk);
        chk(ev_flags[20], "R6 threshold at 7", 64'(ev_flags), 64'h0010_0000);
        ev_mask = 32'h0010_0000;
        #1 chk(irq == 1, "R9 irq masked in", 64'(irq), 1);
        ev_mask = 32'h0;
        #1 chk(irq == 0 && ev_flags[20], "R9 mask off keeps flag", 64'(irq), 0);

        // R7 overflow: fill to 16, 17th dropped
        for (int k = 0; k < 9; k++) begin
            drive_src(0, 1, 0, 1);
            drive_src(0, 0, 0, 0);
        end
        @(negedge clk);
        chk(!ev_flags[28], "R7 no overflow at full", 64'(ev_flags), 0);
        drive_src(0, 1, 0, 0);
        drive_src(0, 0, 0, 0);
        @(negedge clk);
        chk(ev_flags[28], "R7 overflow event", 64'(ev_flags), 64'h1000_0000);
        for (int k = 0; k < 16; k++) mon_pop(0, "R7 contents kept, R3 order");
        @(negedge clk);
        chk(ts_valid == 0, "R3 drained", 64'(ts_valid), 0);

        // R11 pop on empty
        read_word(0, 1, d);
        chk(d == 0, "R11 empty read zero", 64'(d), 0);
        @(negedge clk);
        chk(ts_valid == 0, "R11 still empty", 64'(ts_valid), 0);
        drive_src(0, 1, 0, 1);
        drive_src(0, 0, 0, 0);
        mon_pop(0, "R11 capture after empty pop");

        // R8 loopback on input 1
        @(negedge clk) loop_en[1] = 1;
        drive_src(1, 1, 0, 0);
        drive_src(1, 0, 0, 0);
        @(negedge clk);
        chk(ts_valid == 0, "R8 pin ignored", 64'(ts_valid), 0);
        drive_src(1, 1, 1, 1);
        drive_src(1, 0, 1, 0);
        mon_pop(1, "R8 loopback stamp");
        @(negedge clk) loop_en[1] = 0;

        // R6 programmed threshold on input 1
        clear_events();
        @(negedge clk) thr_we = 1; thr_wdata = 5'd2;
        @(posedge clk); #1 thr_we = 0;
        drive_src(1, 1, 0, 1);
        drive_src(1, 0, 0, 0);
        @(negedge clk);
        chk(!ev_flags[21], "R6 below programmed", 64'(ev_flags), 0);
        drive_src(1, 1, 0, 1);
        drive_src(1, 0, 0, 0);
        @(negedge clk);
        chk(ev_flags[21] && !ev_flags[20], "R6 programmed threshold", 64'(ev_flags), 64'h0020_0000);
        mon_pop(1, "R3 first of two");
        mon_pop(1, "R3 second of two");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule